// File: doc/BRIEF.md
# Register-Mapped Display Identification Read Controller

This block presents four 32-bit registers to a host and behaves like a two-wire bus master whose only reachable target is a local 128-byte display identification ROM. The host picks a port, writes a command holding the target address, a byte count, an optional start index and a cycle type, then polls status and pulls data through a data window, four bytes per read. There is no wire-level signalling. Bus phases (idle, data, wait) move only in response to register accesses. The encoded cycle type decides whether a finished transfer ends in idle or in wait.

Register accesses arrive on a plain request port. A request is accepted in every cycle that `req_valid` is high, with no back-pressure. Every read produces exactly one response, with `rsp_valid` high for one cycle in the cycle after the request. Writes produce no response. The host must accept every response, because nothing in the block holds one back. One input bit per pin reports whether a monitor is attached to that pin.

Top module: `edid_reg_ctrl`

## Requirements
- R1: After reset the status register reads 0x03 (ready and error set, phase idle), and the port, command and data registers read 0.
- R2: Register addresses are 0 port select, 1 command, 2 status and 3 data. Port select reads back its last written value. The command register reads back its stored value, with bit 30 (software ready) always 0.
- R3: A port-select write with a nonzero pin field (bits 2:0) clears the transfer state, sets the phase to idle, clears active (status bit 3) and sets ready (bit 0) and wait-seen (bit 2). It clears error (bit 1) when `mon_attached[pin-1]` is 1 and sets it otherwise. Status bits 7:6 hold the phase: 0 idle, 1 data, 2 wait.
- R4: A command write while stored bit 31 is 0 loads the byte count (bits 24:16) and the cycle type (bits 27:25). Address bits 7:1 equal to 0x50 select the ROM, and any other address does not. Cycle types 1, 3, 5 and 7 set the phase to data and set active.
- R5: A command write with bit 26 set loads the ROM read pointer from bits 15:8.
- R6: With command bit 0 (read) set and bytes remaining (count minus pointer greater than 0), a data-window read returns up to four bytes, the first in bits 7:0, and the upper lanes keep their earlier contents. ROM byte k is k XOR 0xA5. When four or fewer bytes remained, the phase becomes idle for cycle types 5 and 7 and wait for the others, and the transfer state clears.
- R7: A byte is returned as 0, and the pointer does not advance, when no target is selected, when no ROM is available, or when the pointer has reached 128.
- R8: Cycle type 4 (stop) clears the transfer state, sets the phase to idle and clears active, but only when the previously stored cycle type was nonzero. Otherwise it has no effect.
- R9: Writing bit 31 as 1 while the stored bit 31 is 0 sets ready. While the stored bit 31 is 1, a write with bit 31 set is ignored entirely. A write with bit 31 clear clears only that stored bit and resets status to ready, plus error if no ROM is available, with the phase idle.
- R10: A status read returns the value held before the read and then sets in-use (bit 5). Writing 1 to bit 5 clears it. All other status bits ignore writes.
- R11: A data-window read with command bit 0 clear, or with no bytes remaining, returns the last stored data word and changes nothing. Writes to the data window are ignored.
- R12: `rsp_valid` is high in exactly the cycles that follow an accepted read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 32 | Write data |
| mon_attached | input | 7 | Monitor present on pin 1..7 (bit pin-1) |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench drives a transfer that begins at index 126 with a count of 130, so the pointer runs into the ROM end in the middle of one read. A design that wrapped the pointer or miscounted the lanes would return ROM bytes where zeros belong, or would miss the switch to wait. It issues a stop after a "no cycle" command, where a design that ignored the stored cycle type would wrongly drop to idle. It also exercises the clear-interrupt hold and release sequence, reads with the read flag clear, and an unselected target. A design that let those disturb state would show a changed data word, command or phase.

// File: rtl/edid_pkg.sv
package edid_pkg;
  localparam int WORD_W = 32;

  // register addresses
  localparam logic [1:0] RA_PORT = 2'd0;
  localparam logic [1:0] RA_CMD  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_DATA = 2'd3;

  // command fields
  localparam int C_RD     = 0;
  localparam int C_ADR_LO = 1;
  localparam int C_IDX_LO = 8;
  localparam int C_CNT_LO = 16;
  localparam int C_CYC_LO = 25;
  localparam int C_IDXEN  = 26;
  localparam int C_SWRDY  = 30;
  localparam int C_CLRINT = 31;

  localparam logic [6:0] ROM_TARGET = 7'h50;

  localparam logic [2:0] CYC_NONE = 3'd0;
  localparam logic [2:0] CYC_STOP = 3'd4;

  // status bits
  localparam int S_RDY   = 0;
  localparam int S_ERR   = 1;
  localparam int S_WSEEN = 2;
  localparam int S_ACT   = 3;
  localparam int S_INUSE = 5;
  localparam int S_PH_LO = 6;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_WAIT = 2'd2} phase_t;

  function automatic logic [7:0] rom_byte(input logic [7:0] k, input logic [7:0] seed);
    return k ^ seed;
  endfunction
endpackage

// File: rtl/edid_rom.sv
module edid_rom import edid_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int AW = 9,
  parameter int PORTS = 4,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic [PORTS-1:0][AW-1:0] addr,
  output logic [PORTS-1:0][7:0]    data,
  output logic [PORTS-1:0]         hit
);
  for (genvar g = 0; g < PORTS; g++) begin : g_port
    assign hit[g]  = addr[g] < AW'(DEPTH);
    assign data[g] = hit[g] ? rom_byte(addr[g][7:0], SEED) : 8'h00;
  end
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch #(
  parameter int LANES = 4,
  parameter int PTR_W = 8,
  parameter int CNT_W = 9,
  parameter int AW = 9,
  localparam int LW = CNT_W + 1,
  localparam int NG_W = $clog2(LANES + 1)
) (
  input  logic [PTR_W-1:0]          ptr,
  input  logic [CNT_W-1:0]          total,
  input  logic [LANES*8-1:0]        prev_word,
  input  logic                      en,
  output logic [LANES-1:0][AW-1:0]  lane_addr,
  input  logic [LANES-1:0][7:0]     lane_byte,
  input  logic [LANES-1:0]          lane_hit,
  output logic [LANES*8-1:0]        word,
  output logic [NG_W-1:0]           n_got,
  output logic                      has_left,
  output logic                      last
);
  logic signed [LW-1:0] left;
  logic [LW-1:0] lu;
  logic [LANES-1:0] in_take, good;

  assign left = $signed({1'b0, total}) - $signed({{(LW-PTR_W){1'b0}}, ptr});
  assign lu = left;
  assign has_left = !left[LW-1] && (left != '0);
  assign last = has_left && (lu <= LW'(LANES));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = AW'(ptr) + AW'(g);
    assign in_take[g] = has_left && (lu > LW'(g));
    assign good[g] = in_take[g] && en && lane_hit[g];
    assign word[g*8 +: 8] = in_take[g] ? (good[g] ? lane_byte[g] : 8'h00)
                                       : prev_word[g*8 +: 8];
  end

  always_comb begin
    n_got = '0;
    for (int i = 0; i < LANES; i++) n_got = n_got + NG_W'(good[i]);
  end
endmodule

// File: rtl/edid_reg_ctrl.sv
module edid_reg_ctrl import edid_pkg::*; #(
  parameter int ROM_DEPTH = 128,
  parameter logic [7:0] ROM_SEED = 8'hA5,
  parameter int LANES = 4,
  parameter int NPIN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [NPIN-1:0]   mon_attached,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);
  localparam int PTR_W = 8;
  localparam int CNT_W = 9;
  localparam int AW = PTR_W + 1;
  localparam int NG_W = $clog2(LANES + 1);

  logic [WORD_W-1:0] port_q, cmd_q, data_q;
  phase_t phase_q;
  logic rdy_q, err_q, wseen_q, act_q, inuse_q;
  logic tgt_q, avail_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] total_q;
  logic [2:0] cyc_q;

  logic rd, wr;
  assign rd = req_valid && !req_write;
  assign wr = req_valid && req_write;

  // command decode
  logic [2:0] w_cyc, w_pin;
  logic w_data_cyc;
  assign w_cyc = req_wdata[C_CYC_LO +: 3];
  assign w_pin = req_wdata[2:0];
  assign w_data_cyc = w_cyc[0];

  logic [WORD_W-1:0] stat_word;
  assign stat_word = {24'd0, phase_q, inuse_q, 1'b0, act_q, wseen_q, err_q, rdy_q};

  logic [LANES-1:0][AW-1:0] lane_addr;
  logic [LANES-1:0][7:0] lane_byte;
  logic [LANES-1:0] lane_hit;
  logic [WORD_W-1:0] fetch_word;
  logic [NG_W-1:0] n_got;
  logic has_left, last;

  edid_rom #(.DEPTH(ROM_DEPTH), .AW(AW), .PORTS(LANES), .SEED(ROM_SEED)) u_rom (
    .addr(lane_addr), .data(lane_byte), .hit(lane_hit));

  edid_fetch #(.LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W), .AW(AW)) u_fetch (
    .ptr(ptr_q), .total(total_q), .prev_word(data_q), .en(tgt_q && avail_q),
    .lane_addr(lane_addr), .lane_byte(lane_byte), .lane_hit(lane_hit),
    .word(fetch_word), .n_got(n_got), .has_left(has_left), .last(last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= '0; cmd_q <= '0; data_q <= '0;
      phase_q <= PH_IDLE;
      rdy_q <= 1'b1; err_q <= 1'b1; wseen_q <= 1'b0; act_q <= 1'b0; inuse_q <= 1'b0;
      tgt_q <= 1'b0; avail_q <= 1'b0; ptr_q <= '0; total_q <= '0; cyc_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) begin
        unique case (req_addr)
          RA_PORT: rsp_rdata <= port_q;
          RA_CMD:  rsp_rdata <= cmd_q;
          RA_STAT: begin
            rsp_rdata <= stat_word;
            inuse_q <= 1'b1;
          end
          default: begin
            if (cmd_q[C_RD] && has_left) begin
              rsp_rdata <= fetch_word;
              data_q <= fetch_word;
              ptr_q <= ptr_q + PTR_W'(n_got);
              if (last) begin
                phase_q <= (cyc_q[2] && cyc_q[0]) ? PH_IDLE : PH_WAIT;
                tgt_q <= 1'b0; avail_q <= 1'b0; ptr_q <= '0; total_q <= '0; cyc_q <= '0;
              end
            end else begin
              rsp_rdata <= data_q;
            end
          end
        endcase
      end
      if (wr) begin
        unique case (req_addr)
          RA_PORT: begin
            port_q <= req_wdata;
            tgt_q <= 1'b0; avail_q <= 1'b0; ptr_q <= '0; total_q <= '0; cyc_q <= '0;
            phase_q <= PH_IDLE;
            if (w_pin != 3'd0) begin
              act_q <= 1'b0; rdy_q <= 1'b1; wseen_q <= 1'b1;
              if (mon_attached[w_pin - 3'd1]) begin
                avail_q <= 1'b1; err_q <= 1'b0;
              end else begin
                err_q <= 1'b1;
              end
            end
          end
          RA_CMD: begin
            if (cmd_q[C_CLRINT]) begin
              if (!req_wdata[C_CLRINT]) begin
                cmd_q[C_CLRINT] <= 1'b0;
                rdy_q <= 1'b1; err_q <= !avail_q; wseen_q <= 1'b0;
                act_q <= 1'b0; inuse_q <= 1'b0;
                phase_q <= PH_IDLE;
              end
            end else begin
              if (req_wdata[C_CLRINT]) rdy_q <= 1'b1;
              total_q <= req_wdata[C_CNT_LO +: CNT_W];
              if (req_wdata[C_ADR_LO +: 7] == ROM_TARGET) tgt_q <= 1'b1;
              if (req_wdata[C_IDXEN]) ptr_q <= req_wdata[C_IDX_LO +: PTR_W];
              cyc_q <= w_cyc;
              if (w_cyc == CYC_STOP) begin
                if (cmd_q[C_CYC_LO +: 3] != CYC_NONE) begin
                  tgt_q <= 1'b0; avail_q <= 1'b0; ptr_q <= '0; total_q <= '0; cyc_q <= '0;
                  phase_q <= PH_IDLE;
                  act_q <= 1'b0;
                end
              end else if (w_data_cyc) begin
                phase_q <= PH_DATA;
                act_q <= 1'b1;
              end
              cmd_q <= req_wdata & ~(WORD_W'(1) << C_SWRDY);
            end
          end
          RA_STAT: if (req_wdata[S_INUSE]) inuse_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R4
  data_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> act_q);

  // R10
  inuse_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == RA_STAT) |=> inuse_q);

  // R12
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  // R12
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  // R2
  swrdy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == RA_CMD) |=> !rsp_rdata[C_SWRDY]);

  // R3
  port_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == RA_PORT && w_pin != 3'd0) |=> (phase_q == PH_IDLE && !act_q && wseen_q));
endmodule

// File: tb/tb_edid_reg_ctrl.sv
module tb_edid_reg_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [6:0] mon_attached = 7'b0000010;
  logic rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  edid_reg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .mon_attached(mon_attached),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  // monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_stat(input logic [31:0] e, input string t);
    bus_wr(2'd2, 32'h0000_0020);
    bus_rd(2'd2, e, t);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset rsp_valid actual=%b expected=0", rsp_valid);
    end
    // R1 reset state, R10 in-use
    bus_rd(2'd2, 32'h03, "R1 status after reset");
    bus_rd(2'd2, 32'h23, "R10 in-use set by read");
    bus_wr(2'd2, 32'hFFFF_FFFF);
    bus_rd(2'd2, 32'h03, "R10 only in-use clears");
    bus_rd(2'd1, 32'h0, "R1 command after reset");
    bus_rd(2'd0, 32'h0, "R1 port after reset");
    bus_rd(2'd3, 32'h0, "R1 data after reset");
    // R3 port select
    bus_wr(2'd0, 32'd3);
    chk_stat(32'h07, "R3 no monitor sets error");
    bus_wr(2'd0, 32'd2);
    chk_stat(32'h05, "R3 monitor clears error");
    bus_rd(2'd0, 32'd2, "R2 port readback");
    // R4/R6 plain read with stop, 6 bytes
    bus_wr(2'd1, 32'h0A06_00A1);
    chk_stat(32'h4D, "R4 data phase and active");
    bus_rd(2'd3, 32'hA6A7_A4A5, "R6 first four bytes");
    bus_rd(2'd3, 32'hA6A7_A0A1, "R6 two bytes, upper lanes kept");
    chk_stat(32'h0D, "R6 stop variant ends idle");
    bus_rd(2'd3, 32'hA6A7_A0A1, "R11 no bytes left");
    // R5/R7 indexed read across ROM end, wait variant
    bus_wr(2'd0, 32'd2);
    bus_wr(2'd1, 32'h0682_7EA1);
    bus_rd(2'd3, 32'h0000_DADB, "R5 R7 index load and ROM end");
    chk_stat(32'h8D, "R6 wait variant ends in wait");
    // R8 stop after a data cycle
    bus_wr(2'd1, 32'h0800_0000);
    chk_stat(32'h05, "R8 stop returns idle");
    bus_rd(2'd1, 32'h0800_0000, "R2 command readback");
    // R8 stop after no-cycle is ignored
    bus_wr(2'd0, 32'd2);
    bus_wr(2'd1, 32'h0208_00A1);
    bus_wr(2'd1, 32'h0);
    bus_wr(2'd1, 32'h0800_0000);
    chk_stat(32'h4D, "R8 stop ignored after no-cycle");
    // R11 read flag clear
    bus_wr(2'd0, 32'd2);
    bus_wr(2'd1, 32'h0A04_00A0);
    bus_rd(2'd3, 32'h0000_DADB, "R11 read flag clear");
    bus_wr(2'd3, 32'h1234_5678);
    bus_rd(2'd3, 32'h0000_DADB, "R11 data write ignored");
    chk_stat(32'h4D, "R11 no side effects");
    // R7 no ROM available
    bus_wr(2'd0, 32'd3);
    bus_wr(2'd1, 32'h0A04_00A1);
    bus_rd(2'd3, 32'h0, "R7 no ROM returns zeros");
    chk_stat(32'h0F, "R7 status after unavailable read");
    // R7 target not selected
    bus_wr(2'd0, 32'd2);
    bus_wr(2'd1, 32'h0A04_00A3);
    bus_wr(2'd3, 32'h0);
    bus_rd(2'd3, 32'h0, "R7 unselected target returns zeros");
    chk_stat(32'h0D, "R7 status after unselected read");
    // R2 software ready forced low
    bus_wr(2'd1, 32'h4000_0000);
    bus_rd(2'd1, 32'h0, "R2 software ready stored as 0");
    // R9 clear-interrupt sequence
    bus_wr(2'd0, 32'd2);
    bus_wr(2'd1, 32'h8208_00A1);
    chk_stat(32'h4D, "R9 set clear bit");
    bus_wr(2'd1, 32'h8000_0000);
    bus_rd(2'd1, 32'h8208_00A1, "R9 write ignored while held");
    chk_stat(32'h4D, "R9 status untouched while held");
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, 32'h0208_00A1, "R9 release clears only bit 31");
    chk_stat(32'h01, "R9 release resets status");
    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R12 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule